// File: doc/BRIEF.md
# Device Interrupt Masking Router

This block takes device interrupt events and routes them to up to four processors. It holds a 64-bit vector of pending device requests. Each request line is raised or withdrawn by a set or clear strobe that carries the line number. Each processor has a 64-bit enable mask. The processor's effective vector is the mask ANDed with the pending vector. The processor's interrupt output is high while that effective vector has any bit set.

Software reaches the block through a simple register port. The port accepts one access per cycle and returns the result one cycle later. Through it software writes and reads the masks, and reads the effective vectors and the pending vector. An access the block cannot serve returns a one-cycle error pulse and changes no state. The effective vectors are always derived from the current masks and the pending vector, so a mask write or a request event is seen in all of them at once.

Top module: `dimr_top`

## Requirements
- R1: After reset all masks, the pending vector and all effective vectors read zero, every interrupt output is low and the error output is low.
- R2: A 64-bit write to processor k's mask stores the write data. Reading that processor's effective vector afterwards returns the new mask ANDed with the pending vector.
- R3: A set strobe with number n sets pending bit n. From then on, the output of every processor whose mask has bit n set is high.
- R4: A clear strobe for a pending bit that is already clear changes no state and no output.
- R5: A clear strobe for a set pending bit clears that bit. Any processor whose effective vector then becomes zero drops its output.
- R6: Each interrupt output is the OR of that processor's effective vector, registered once. It changes on the clock edge after the edge that updated the mask or the pending vector.
- R7: Address map, with the byte offset shifted right by 6 giving the register number. Register numbers 0 to 3 are the masks of processors 0 to 3. Numbers 8 to 11 are the effective vectors of processors 0 to 3. Number 16 is the pending vector. Offset bit 12 selects a mask window and offset bit 13 selects an effective window. In either window the processor index is offset bits 9:4. Bit 12 wins when both bits are set.
- R8: Access size is encoded 0, 1, 2 and 3 for 8, 16, 32 and 64 bits. Only 64-bit accesses are served. The one exception is a 32-bit read of the pending vector, which returns its low 32 bits zero-extended.
- R9: These accesses pulse the error output and return read data zero, and they change no mask and no pending bit: a write to an effective vector or to the pending vector, a size not allowed by R8, an unmapped register number, and a window index of 4 or more.
- R10: A set and a clear strobe for the same number in the same cycle leave that pending bit set.
- R11: Read data and the error pulse appear on the cycle after the access is presented. A write returns read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_set_i | input | 1 | Raise the device line given by dev_num_i |
| dev_clr_i | input | 1 | Withdraw the device line given by dev_num_i |
| dev_num_i | input | 6 | Device line number |
| acc_req_i | input | 1 | Register access valid this cycle |
| acc_we_i | input | 1 | 1 for write, 0 for read |
| acc_size_i | input | 2 | Access size code (R8) |
| acc_addr_i | input | 16 | Byte offset of the access |
| acc_wdata_i | input | 64 | Write data |
| acc_rdata_o | output | 64 | Read data, one cycle after the access |
| acc_err_o | output | 1 | Unsupported-access pulse, one cycle after the access |
| dev_irq_o | output | 4 | Device interrupt, one bit per processor |

## Verification
The assertions check several properties on every cycle. Each interrupt output matches the registered OR of its mask ANDed with the pending vector. Set strobes land in the pending vector, a set beats a clear, clears of set bits take effect, and spurious clears leave the vector untouched. An error pulse comes with zero read data and no mask change. Only the bench's scenarios can show the rest. These are the address map with its two windows and their priority, the size rules, including the half-width pending read, and the read-back of every mask and effective vector. The bench also sweeps all 64 line numbers against a mix of masks to show which processors are reached.

// File: rtl/dimr_pkg.sv
package dimr_pkg;
  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } acc_size_e;

  localparam int RN_EFF_BASE  = 8;
  localparam int RN_REQ       = 16;
  localparam int MASK_WIN_BIT = 12;
  localparam int EFF_WIN_BIT  = 13;
  localparam int IDX_LSB      = 4;
  localparam int IDX_W        = 6;
  localparam int RN_LSB       = 6;
endpackage

// File: rtl/dimr_req_vec.sv
module dimr_req_vec #(
  parameter int VEC_W = 64,
  parameter int NUM_W = $clog2(VEC_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [VEC_W-1:0] req_o
);
  logic [VEC_W-1:0] req_q, req_d;

  // set is applied after clear so it wins on the same line
  always_comb begin
    req_d = req_q;
    if (clr_i) req_d[num_i] = 1'b0;
    if (set_i) req_d[num_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/dimr_mask_bank.sv
module dimr_mask_bank #(
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CPU-1:0]            wr_en_i,
  input  logic [VEC_W-1:0]              wdata_i,
  input  logic [VEC_W-1:0]              req_i,
  output logic [NUM_CPU-1:0][VEC_W-1:0] mask_o,
  output logic [NUM_CPU-1:0][VEC_W-1:0] eff_o,
  output logic [NUM_CPU-1:0]            irq_o
);
  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    logic [VEC_W-1:0] mask_q;
    logic             irq_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q <= '0;
      else if (wr_en_i[k]) mask_q <= wdata_i;
    end

    assign eff_o[k]  = mask_q & req_i;
    assign mask_o[k] = mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |eff_o[k];
    end

    assign irq_o[k] = irq_q;
  end
endmodule

// File: rtl/dimr_csr_port.sv
module dimr_csr_port
  import dimr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 64,
  parameter int ADDR_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [1:0]                    size_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_CPU-1:0][VEC_W-1:0] mask_i,
  input  logic [NUM_CPU-1:0][VEC_W-1:0] eff_i,
  input  logic [VEC_W-1:0]              reqv_i,
  output logic [NUM_CPU-1:0]            mask_we_o,
  output logic [VEC_W-1:0]              rdata_o,
  output logic                          err_o
);
  localparam int RN_W  = ADDR_W - RN_LSB;
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int HALF  = VEC_W / 2;

  logic [RN_W-1:0]  rnum;
  logic [IDX_W-1:0] win_idx, cpu_idx;
  logic [CPU_W-1:0] cpu_sel;
  logic             sel_mask, sel_eff, sel_req, bad, half_rd;
  logic [VEC_W-1:0] rd_val;
  logic [VEC_W-1:0] rdata_q;
  logic             err_q;

  assign rnum    = addr_i[ADDR_W-1:RN_LSB];
  assign win_idx = addr_i[IDX_LSB +: IDX_W];
  assign cpu_sel = cpu_idx[CPU_W-1:0];

  always_comb begin
    sel_mask = 1'b0;
    sel_eff  = 1'b0;
    sel_req  = 1'b0;
    bad      = 1'b0;
    cpu_idx  = '0;
    if (addr_i[MASK_WIN_BIT]) begin
      sel_mask = 1'b1;
      cpu_idx  = win_idx;
    end else if (addr_i[EFF_WIN_BIT]) begin
      sel_eff = 1'b1;
      cpu_idx = win_idx;
    end else if (rnum < RN_W'(NUM_CPU)) begin
      sel_mask = 1'b1;
      cpu_idx  = IDX_W'(rnum);
    end else if (rnum >= RN_W'(RN_EFF_BASE) && rnum < RN_W'(RN_EFF_BASE + NUM_CPU)) begin
      sel_eff = 1'b1;
      cpu_idx = IDX_W'(rnum - RN_W'(RN_EFF_BASE));
    end else if (rnum == RN_W'(RN_REQ)) begin
      sel_req = 1'b1;
    end else begin
      bad = 1'b1;
    end

    half_rd = sel_req && !we_i && (size_i == SZ_32);
    if ((sel_mask || sel_eff) && cpu_idx >= IDX_W'(NUM_CPU)) bad = 1'b1;
    if ((sel_eff || sel_req) && we_i)                        bad = 1'b1;
    if ((size_i != SZ_64) && !half_rd)                       bad = 1'b1;
  end

  always_comb begin
    if (sel_mask)     rd_val = mask_i[cpu_sel];
    else if (sel_eff) rd_val = eff_i[cpu_sel];
    else if (half_rd) rd_val = {{(VEC_W-HALF){1'b0}}, reqv_i[HALF-1:0]};
    else if (sel_req) rd_val = reqv_i;
    else              rd_val = '0;
  end

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_we
    assign mask_we_o[k] = req_i && we_i && sel_mask && !bad && (cpu_sel == CPU_W'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (req_i && !we_i && !bad) ? rd_val : '0;
      err_q   <= req_i && bad;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/dimr_top.sv
module dimr_top #(
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 64,
  parameter int ADDR_W  = 16,
  parameter int NUM_W   = $clog2(VEC_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dev_set_i,
  input  logic               dev_clr_i,
  input  logic [NUM_W-1:0]   dev_num_i,
  input  logic               acc_req_i,
  input  logic               acc_we_i,
  input  logic [1:0]         acc_size_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [VEC_W-1:0]   acc_wdata_i,
  output logic [VEC_W-1:0]   acc_rdata_o,
  output logic               acc_err_o,
  output logic [NUM_CPU-1:0] dev_irq_o
);
  logic [VEC_W-1:0]              req_vec;
  logic [NUM_CPU-1:0][VEC_W-1:0] mask_vec;
  logic [NUM_CPU-1:0][VEC_W-1:0] eff_vec;
  logic [NUM_CPU-1:0]            mask_we;

  dimr_req_vec #(.VEC_W(VEC_W), .NUM_W(NUM_W)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dev_set_i),
    .clr_i  (dev_clr_i),
    .num_i  (dev_num_i),
    .req_o  (req_vec)
  );

  dimr_mask_bank #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (mask_we),
    .wdata_i (acc_wdata_i),
    .req_i   (req_vec),
    .mask_o  (mask_vec),
    .eff_o   (eff_vec),
    .irq_o   (dev_irq_o)
  );

  dimr_csr_port #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (acc_req_i),
    .we_i      (acc_we_i),
    .size_i    (acc_size_i),
    .addr_i    (acc_addr_i),
    .mask_i    (mask_vec),
    .eff_i     (eff_vec),
    .reqv_i    (req_vec),
    .mask_we_o (mask_we),
    .rdata_o   (acc_rdata_o),
    .err_o     (acc_err_o)
  );
endmodule

// File: rtl/dimr_checker.sv
module dimr_checker #(
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 64,
  parameter int NUM_W   = 6
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          dev_set_i,
  input logic                          dev_clr_i,
  input logic [NUM_W-1:0]              dev_num_i,
  input logic [VEC_W-1:0]              acc_rdata_o,
  input logic                          acc_err_o,
  input logic [NUM_CPU-1:0]            dev_irq_o,
  input logic [VEC_W-1:0]              req_q,
  input logic [NUM_CPU-1:0][VEC_W-1:0] mask_q
);
  assert_set_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_set_i |=> req_q[$past(dev_num_i)]);

  assert_set_beats_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_set_i && dev_clr_i) |=> req_q[$past(dev_num_i)]);

  assert_spurious_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_clr_i && !dev_set_i && !req_q[dev_num_i]) |=> $stable(req_q));

  assert_clear_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_clr_i && !dev_set_i) |=> !req_q[$past(dev_num_i)]);

  assert_err_zero_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> (acc_rdata_o == '0));

  assert_err_no_mask_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> (mask_q == $past(mask_q)));

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_irq
    assert_irq_tracks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dev_irq_o[k] == $past(|(mask_q[k] & req_q)));
  end
endmodule

bind dimr_top dimr_checker #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .NUM_W(NUM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_set_i   (dev_set_i),
  .dev_clr_i   (dev_clr_i),
  .dev_num_i   (dev_num_i),
  .acc_rdata_o (acc_rdata_o),
  .acc_err_o   (acc_err_o),
  .dev_irq_o   (dev_irq_o),
  .req_q       (req_vec),
  .mask_q      (mask_vec)
);

// File: tb/tb_dimr_top.sv
module tb_dimr_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dev_set_i = 1'b0, dev_clr_i = 1'b0;
  logic [5:0]  dev_num_i = '0;
  logic        acc_req_i = 1'b0, acc_we_i = 1'b0;
  logic [1:0]  acc_size_i = 2'd3;
  logic [15:0] acc_addr_i = '0;
  logic [63:0] acc_wdata_i = '0;
  logic [63:0] acc_rdata_o;
  logic        acc_err_o;
  logic [3:0]  dev_irq_o;

  int n_chk = 0, n_fail = 0;
  logic [63:0] m_mask [4];
  logic [63:0] m_req;

  always #2.5 clk_i = ~clk_i;

  dimr_top dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [1:0] sz, input logic [15:0] a,
                     input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk_i);
    acc_req_i = 1'b1; acc_we_i = we; acc_size_i = sz; acc_addr_i = a; acc_wdata_i = wd;
    @(negedge clk_i);
    acc_req_i = 1'b0; acc_we_i = 1'b0;
    rd = acc_rdata_o; er = acc_err_o;
  endtask

  task automatic dev(input logic s, input logic c, input int n);
    @(negedge clk_i);
    dev_set_i = s; dev_clr_i = c; dev_num_i = 6'(n);
    @(negedge clk_i);
    dev_set_i = 1'b0; dev_clr_i = 1'b0;
    if (c) m_req[n] = 1'b0;
    if (s) m_req[n] = 1'b1;
  endtask

  function automatic logic [15:0] a_mask(int k); return 16'(k << 6); endfunction
  function automatic logic [15:0] a_eff(int k);  return 16'((8 + k) << 6); endfunction
  function automatic logic [15:0] w_mask(int k); return 16'h1000 | 16'(k << 4); endfunction
  function automatic logic [15:0] w_eff(int k);  return 16'h2000 | 16'(k << 4); endfunction
  localparam logic [15:0] A_REQ = 16'h0400;

  task automatic chk_irq(input string tag);
    for (int k = 0; k < 4; k++) chk(tag, 64'(dev_irq_o[k]), 64'(|(m_mask[k] & m_req)));
  endtask

  task automatic chk_state(input string tag);
    logic [63:0] rd; logic er;
    for (int k = 0; k < 4; k++) begin
      acc(1'b0, 2'd3, a_mask(k), '0, rd, er); chk(tag, rd, m_mask[k]);
    end
    acc(1'b0, 2'd3, A_REQ, '0, rd, er); chk(tag, rd, m_req);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] rd; logic er; logic [3:0] irq_before;
    for (int k = 0; k < 4; k++) m_mask[k] = '0;
    m_req = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq", 64'(dev_irq_o), 64'h0);
    chk("R1 err", 64'(acc_err_o), 64'h0);
    for (int k = 0; k < 4; k++) begin
      acc(1'b0, 2'd3, a_mask(k), '0, rd, er); chk("R1 mask", rd, 64'h0);
      acc(1'b0, 2'd3, a_eff(k), '0, rd, er);  chk("R1 eff", rd, 64'h0);
    end
    acc(1'b0, 2'd3, A_REQ, '0, rd, er); chk("R1 req", rd, 64'h0);

    // R2 R7 R11 mask writes, primary and window
    m_mask[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    m_mask[1] = 64'h5555_5555_5555_5555;
    m_mask[2] = 64'h8000_0000_0000_0001;
    m_mask[3] = 64'h00FF_0000_F0F0_0000;
    for (int k = 0; k < 3; k++) begin
      acc(1'b1, 2'd3, a_mask(k), m_mask[k], rd, er);
      chk("R11 write rdata", rd, 64'h0);
      chk("R11 write err", 64'(er), 64'h0);
    end
    acc(1'b1, 2'd3, w_mask(3), m_mask[3], rd, er);
    for (int k = 0; k < 4; k++) begin
      acc(1'b0, 2'd3, w_mask(k), '0, rd, er); chk("R7 window mask", rd, m_mask[k]);
      acc(1'b0, 2'd3, a_mask(k), '0, rd, er); chk("R2 mask readback", rd, m_mask[k]);
    end

    // R3 R5 R6 sweep of every line
    for (int n = 0; n < 64; n++) begin
      irq_before = dev_irq_o;
      dev(1'b1, 1'b0, n);
      chk("R6 latency", 64'(dev_irq_o), 64'(irq_before));
      @(negedge clk_i);
      chk_irq("R3 irq");
      acc(1'b0, 2'd3, A_REQ, '0, rd, er); chk("R3 req", rd, m_req);
      for (int k = 0; k < 4; k++) begin
        acc(1'b0, 2'd3, w_eff(k), '0, rd, er); chk("R7 window eff", rd, m_mask[k] & m_req);
      end
      dev(1'b0, 1'b1, n);
      @(negedge clk_i);
      chk("R5 irq drop", 64'(dev_irq_o), 64'h0);
      acc(1'b0, 2'd3, A_REQ, '0, rd, er); chk("R5 req", rd, 64'h0);
    end

    // R4 spurious clear
    dev(1'b1, 1'b0, 0);
    dev(1'b1, 1'b0, 40);
    @(negedge clk_i);
    irq_before = dev_irq_o;
    dev(1'b0, 1'b1, 17);
    @(negedge clk_i);
    chk("R4 irq", 64'(dev_irq_o), 64'(irq_before));
    chk_state("R4 state");

    // R10 simultaneous set and clear
    dev(1'b1, 1'b1, 9);
    acc(1'b0, 2'd3, A_REQ, '0, rd, er); chk("R10 req", rd, m_req);
    dev(1'b1, 1'b1, 40);
    acc(1'b0, 2'd3, A_REQ, '0, rd, er); chk("R10 req held", rd, m_req);

    // R2 mask write recomputes effective, R5 output drop
    m_mask[2] = 64'h0;
    acc(1'b1, 2'd3, a_mask(2), m_mask[2], rd, er);
    @(negedge clk_i);
    chk_irq("R2 irq after mask");
    for (int k = 0; k < 4; k++) begin
      acc(1'b0, 2'd3, a_eff(k), '0, rd, er); chk("R2 eff", rd, m_mask[k] & m_req);
    end

    // R8 half read of request
    dev(1'b1, 1'b0, 3);
    acc(1'b0, 2'd2, A_REQ, '0, rd, er);
    chk("R8 half read", rd, {32'h0, m_req[31:0]});
    chk("R8 half err", 64'(er), 64'h0);

    // R9 unsupported accesses
    acc(1'b1, 2'd3, a_eff(1), 64'hDEAD, rd, er); chk("R9 eff write", 64'(er), 64'h1);
    acc(1'b1, 2'd3, w_eff(0), 64'hDEAD, rd, er); chk("R9 eff win write", 64'(er), 64'h1);
    acc(1'b1, 2'd3, A_REQ, 64'hDEAD, rd, er);    chk("R9 req write", 64'(er), 64'h1);
    acc(1'b0, 2'd2, a_mask(0), '0, rd, er);
    chk("R9 32b mask read", 64'(er), 64'h1); chk("R9 zero data", rd, 64'h0);
    acc(1'b0, 2'd0, A_REQ, '0, rd, er);          chk("R9 8b req read", 64'(er), 64'h1);
    acc(1'b1, 2'd1, a_mask(1), 64'h1, rd, er);   chk("R9 16b mask write", 64'(er), 64'h1);
    acc(1'b1, 2'd2, A_REQ, 64'h1, rd, er);       chk("R9 32b req write", 64'(er), 64'h1);
    acc(1'b0, 2'd3, 16'(20 << 6), '0, rd, er);   chk("R9 unmapped", 64'(er), 64'h1);
    acc(1'b1, 2'd3, w_mask(5), 64'h1, rd, er);   chk("R9 window index", 64'(er), 64'h1);
    acc(1'b0, 2'd3, a_mask(3), '0, rd, er);      chk("R9 err clears", 64'(er), 64'h0);
    chk_state("R9 state");

    // R7 both window bits pick the mask window
    acc(1'b0, 2'd3, 16'h3000 | 16'(1 << 4), '0, rd, er);
    chk("R7 window priority", rd, m_mask[1]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule